// File: doc/BRIEF.md
# Column-Walking Byte Reader

This block reads one byte out of a one-bit-wide, bit-addressed storage array. The array is arranged as columns of eight rows, and each column holds one byte. The block sits beside an 8-bit select register, whose low three bits name the row and whose next three bits name the column. A sense stage returns the single array bit that the register currently points at.

A one-cycle start request carries a column number. On that request the reader points the select register at row 0 of the column. It then waits one cycle so that the sensed bit reflects the new select value. After that it repeats a fixed pair of steps: it stores the sensed bit in the byte, then adds one to the select register. It keeps no bit counter of its own. After the eighth step the select register has crossed into row 0 of the next column, the row-zero flag goes high, and the reader ends the walk with a single-cycle done strobe.

As an option, the finished byte can be written back into the select register. A later read of that register then returns the byte directly.

Top module: `col_byte_reader`

## Requirements
- R1: While reset is held and after it is released, the outputs read as follows: sel_o is 0x00, row_zero_o is 1, byte_o is 0x00, busy_o is 0 and done_o is 0.
- R2: A start_i that the reader samples while it is idle sets sel_o to {2'b00, col_i, 3'b000}, which is row 0 of the requested column. In the cycle after that edge, busy_o is 1.
- R3: sel_o bits [2:0] give the row and bits [5:3] give the column. The bit that is read is array_i[column*8 + row]. Row n of the column is placed in byte_o bit n, so the finished byte_o equals array_i[column*8 +: 8].
- R4: During a walk, sel_o changes only by one increment of bits [5:0]. busy_o falls only at the same edge where done_o rises. done_o rises at the 17th rising edge after the edge that accepted the start.
- R5: done_o is high for exactly one cycle. byte_o keeps its value until the next accepted start.
- R6: A start_i that arrives while busy_o is 1 is ignored. The running walk finishes with its own column, byte and timing.
- R7: For column 7, the final increment wraps sel_o to 0x00, which is column 0 row 0. This still ends the walk.
- R8: row_zero_o is 1 exactly when sel_o bits [2:0] are zero.
- R9: If writeback_i was 1 when the start was accepted, sel_o equals byte_o after done. Otherwise sel_o points at row 0 of the next column, with bits [7:6] equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to read one column |
| col_i | input | 3 | Column to read |
| writeback_i | input | 1 | When 1, copy the finished byte into the select register |
| array_i | input | 64 | Contents of the bit array, indexed by column*8+row |
| sel_o | output | 8 | Select register |
| row_zero_o | output | 1 | High when the select register points at row 0 |
| busy_o | output | 1 | A walk is in progress |
| byte_o | output | 8 | Assembled byte |
| done_o | output | 1 | One-cycle strobe marking the end of a walk |

## Verification
The walk is run on the first, a middle and the last column, with arrays that are all ones, all zeros, a single set bit at each end of the array, and ramp or mixed patterns. A bit order reversed between row and byte position, or a column offset mixed up with the row, gives a different byte on these patterns. Column 7 and the write-back option separate the two possible endings: a wrap to 0x00, and a select register loaded with the byte. A start issued in mid-walk, and a reset applied in mid-walk, show whether the sequence can be disturbed. Measuring the latency to done shows whether the reader stopped on the row-zero flag or one step early or late.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    W_IDLE   = 2'd0,
    W_SETTLE = 2'd1,
    W_TAKE   = 2'd2,
    W_CHECK  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/cbr_select_reg.sv
module cbr_select_reg #(
  parameter int ROWW = 3,
  parameter int COLW = 3,
  parameter int SELW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [COLW-1:0] col_i,
  input  logic            step_i,
  input  logic            wb_i,
  input  logic [SELW-1:0] wb_val_i,
  output logic [SELW-1:0] sel_o,
  output logic            row_zero_o
);
  localparam int IDXW = ROWW + COLW;

  function automatic logic [SELW-1:0] first_of_col(input logic [COLW-1:0] c);
    logic [SELW-1:0] r;
    r = '0;
    r[IDXW-1:ROWW] = c;
    return r;
  endfunction

  function automatic logic [SELW-1:0] step_sel(input logic [SELW-1:0] s);
    logic [SELW-1:0] r;
    r = s;
    r[IDXW-1:0] = s[IDXW-1:0] + IDXW'(1);
    return r;
  endfunction

  logic [SELW-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       sel_q <= '0;
    else if (wb_i)    sel_q <= wb_val_i;
    else if (load_i)  sel_q <= first_of_col(col_i);
    else if (step_i)  sel_q <= step_sel(sel_q);
  end

  assign sel_o      = sel_q;
  assign row_zero_o = (sel_q[ROWW-1:0] == '0);
endmodule

// File: rtl/cbr_sense.sv
module cbr_sense #(
  parameter int NBITS = 64,
  parameter int IDXW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] array_i,
  input  logic [IDXW-1:0]  idx_i,
  output logic             bit_o
);
  logic sense_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sense_q <= 1'b0;
    else        sense_q <= array_i[idx_i];
  end

  assign bit_o = sense_q;
endmodule

// File: rtl/cbr_walk_ctrl.sv
module cbr_walk_ctrl
  import cbr_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int ROWW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            wb_req_i,
  input  logic [ROWW-1:0] row_i,
  input  logic            row_zero_i,
  input  logic            bit_i,
  output logic            load_o,
  output logic            step_o,
  output logic            wb_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [ROWS-1:0] byte_o
);
  function automatic logic [ROWS-1:0] put_bit(input logic [ROWS-1:0] b,
                                              input logic [ROWW-1:0] pos,
                                              input logic            v);
    logic [ROWS-1:0] r;
    r = b;
    r[pos] = v;
    return r;
  endfunction

  walk_st_e        st_q;
  logic            wb_keep_q;
  logic            done_q;
  logic [ROWS-1:0] byte_q;
  logic            finish_evt;

  assign load_o     = (st_q == W_IDLE) && start_i;
  assign step_o     = (st_q == W_TAKE);
  assign finish_evt = (st_q == W_CHECK) && row_zero_i;
  assign wb_o       = finish_evt && wb_keep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= W_IDLE;
      wb_keep_q <= 1'b0;
      done_q    <= 1'b0;
      byte_q    <= '0;
    end else begin
      done_q <= finish_evt;
      unique case (st_q)
        W_IDLE: if (start_i) begin
          byte_q    <= '0;
          wb_keep_q <= wb_req_i;
          st_q      <= W_SETTLE;
        end
        W_SETTLE: st_q <= W_TAKE;
        W_TAKE: begin
          byte_q <= put_bit(byte_q, row_i, bit_i);
          st_q   <= W_CHECK;
        end
        W_CHECK: st_q <= row_zero_i ? W_IDLE : W_TAKE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != W_IDLE);
  assign done_o = done_q;
  assign byte_o = byte_q;
endmodule

// File: rtl/col_byte_reader.sv
module col_byte_reader #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int SELW = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [$clog2(COLS)-1:0]      col_i,
  input  logic                         writeback_i,
  input  logic [ROWS*COLS-1:0]         array_i,
  output logic [SELW-1:0]              sel_o,
  output logic                         row_zero_o,
  output logic                         busy_o,
  output logic [ROWS-1:0]              byte_o,
  output logic                         done_o
);
  localparam int ROWW  = $clog2(ROWS);
  localparam int COLW  = $clog2(COLS);
  localparam int IDXW  = ROWW + COLW;
  localparam int NBITS = ROWS * COLS;

  function automatic logic [SELW-1:0] fit_sel(input logic [ROWS-1:0] b);
    return SELW'(b);
  endfunction

  logic load_evt, step_evt, wb_evt;
  logic sensed_bit;
  logic [SELW-1:0] sel_w;
  logic row_zero_w;
  logic [ROWS-1:0] byte_w;

  cbr_select_reg #(.ROWW(ROWW), .COLW(COLW), .SELW(SELW)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_evt),
    .col_i      (col_i),
    .step_i     (step_evt),
    .wb_i       (wb_evt),
    .wb_val_i   (fit_sel(byte_w)),
    .sel_o      (sel_w),
    .row_zero_o (row_zero_w)
  );

  cbr_sense #(.NBITS(NBITS), .IDXW(IDXW)) u_sense (
    .clk     (clk),
    .rst_n   (rst_n),
    .array_i (array_i),
    .idx_i   (sel_w[IDXW-1:0]),
    .bit_o   (sensed_bit)
  );

  cbr_walk_ctrl #(.ROWS(ROWS), .ROWW(ROWW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .wb_req_i   (writeback_i),
    .row_i      (sel_w[ROWW-1:0]),
    .row_zero_i (row_zero_w),
    .bit_i      (sensed_bit),
    .load_o     (load_evt),
    .step_o     (step_evt),
    .wb_o       (wb_evt),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .byte_o     (byte_w)
  );

  assign sel_o      = sel_w;
  assign row_zero_o = row_zero_w;
  assign byte_o     = byte_w;
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int SELW = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic [$clog2(COLS)-1:0] col_i,
  input logic [SELW-1:0]         sel_o,
  input logic                    row_zero_o,
  input logic                    busy_o,
  input logic [ROWS-1:0]         byte_o,
  input logic                    done_o
);
  localparam int ROWW = $clog2(ROWS);
  localparam int COLW = $clog2(COLS);
  localparam int IDXW = ROWW + COLW;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && sel_o[IDXW-1:0] == {$past(col_i), {ROWW{1'b0}}}));

  assert_busy_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (done_o || $stable(sel_o) ||
                sel_o[IDXW-1:0] == $past(sel_o[IDXW-1:0]) + IDXW'(1)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_byte_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(byte_o));

  assert_row_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    row_zero_o == (sel_o[ROWW-1:0] == '0));
endmodule

bind col_byte_reader cbr_checker #(.ROWS(ROWS), .COLS(COLS), .SELW(SELW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .col_i      (col_i),
  .sel_o      (sel_o),
  .row_zero_o (row_zero_o),
  .busy_o     (busy_o),
  .byte_o     (byte_o),
  .done_o     (done_o)
);

// File: tb/tb_col_byte_reader.sv
module tb_col_byte_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  col_i = '0;
  logic        writeback_i = 1'b0;
  logic [63:0] array_i = '0;
  logic [7:0]  sel_o;
  logic        row_zero_o;
  logic        busy_o;
  logic [7:0]  byte_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  col_byte_reader dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .writeback_i(writeback_i), .array_i(array_i), .sel_o(sel_o),
    .row_zero_o(row_zero_o), .busy_o(busy_o), .byte_o(byte_o), .done_o(done_o)
  );

  localparam int NV = 8;
  localparam logic [63:0] V_ARR [NV] = '{
    64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0001,
    64'h8000_0000_0000_0001, 64'hA5C3_0F1E_2D3C_4B5A};
  localparam logic [2:0] V_COL [NV] = '{3'd0, 3'd3, 3'd7, 3'd5, 3'd2, 3'd7, 3'd0, 3'd4};
  localparam bit         V_WB  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [63:0] arr, input logic [2:0] col, input bit wb,
                         input bit inject);
    logic [7:0] exp_byte, exp_sel, sel0;
    int lat;
    array_i = arr; col_i = col; writeback_i = wb; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; writeback_i = 1'b0;
    sel0 = {2'b00, col, 3'b000};
    check(sel_o == sel0, "R2 sel", sel_o, sel0);
    check(busy_o == 1'b1, "R2 busy", busy_o, 1);
    lat = 0;
    for (int i = 1; i < 40; i++) begin
      if (inject && i == 5) begin
        start_i = 1'b1; col_i = col ^ 3'd5; writeback_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0; writeback_i = 1'b0;
      if (done_o) begin lat = i; break; end
    end
    exp_byte = arr[int'(col)*8 +: 8];
    exp_sel  = wb ? exp_byte : {2'b00, col + 3'd1, 3'b000};
    check(lat == 17, inject ? "R6 R4 latency" : "R4 latency", lat, 17);
    check(byte_o == exp_byte, inject ? "R6 R3 byte" : "R3 byte", byte_o, exp_byte);
    check(sel_o == exp_sel, (col == 3'd7 && !wb) ? "R7 R9 sel" : "R9 sel", sel_o, exp_sel);
    check(row_zero_o == (exp_sel[2:0] == 3'b000), "R8 flag", row_zero_o, exp_sel[2:0] == 3'b000);
    check(busy_o == 1'b0, "R4 busy", busy_o, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R5 pulse", done_o, 0);
    repeat (3) @(negedge clk);
    check(byte_o == exp_byte, "R5 hold", byte_o, exp_byte);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sel_o == 8'h00 && row_zero_o && byte_o == 8'h00 && !busy_o && !done_o,
          "R1 reset", {sel_o, byte_o, row_zero_o, busy_o, done_o}, 19'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(sel_o == 8'h00 && row_zero_o && !busy_o, "R1 after release", sel_o, 0);

    for (int v = 0; v < NV; v++) do_read(V_ARR[v], V_COL[v], V_WB[v], 1'b0);

    do_read(64'h0123_4567_89AB_CDEF, 3'd1, 1'b0, 1'b1);

    array_i = 64'hFFFF_FFFF_FFFF_FFFF; col_i = 3'd6; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(sel_o == 8'h00 && row_zero_o && byte_o == 8'h00 && !busy_o && !done_o,
          "R1 mid-walk reset", {sel_o, byte_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(64'h0011_2233_4455_6677, 3'd6, 1'b0, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule